// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer

This block is a single-channel 16-bit down counter that produces periodic events or single timed pulses. Each step of the counter comes from a count clock. That clock is either a tick from a free-running prescaler on the system clock or a rising edge on an external event input. The event input is synchronised through two flip-flops before its edges are detected.

Software sets up the timer through a plain write strobe and a combinational read port. It writes the reload value and the control word, then pulses the trigger input. The trigger loads the counter from the reload register and starts the countdown.

When the counter is at zero and a count step arrives, an underflow occurs. What follows depends on the mode:
- In reload mode the counter refills from the reload register, and the timer pin toggles on every underflow.
- In one-shot mode the counter stops at the underflow. The pin is active from the trigger until that underflow.

Every underflow also latches a sticky flag. The flag raises the interrupt output when the interrupt enable is set.

Top module: `intv_timer`

## Requirements
- R1: After reset the timer pin and the interrupt are low, and the control, reload and counter registers all read 0.
- R2: Address 0 is the control word:
  - bit 0 is the enable;
  - bit 1 selects the mode (1 reload, 0 one-shot);
  - bit 2 is the output invert;
  - bit 3 is the interrupt enable;
  - bit 4 is the underflow flag;
  - bits 7:5 are the clock select.

  Address 1 is the 16-bit reload register, which holds any value from 0 to 0xFFFF. Address 2 reads the counter. A trigger with the enable set loads the counter from the reload register on that clock edge.
- R3: In reload mode two successive underflows lie exactly (reload+1)×D system clock cycles apart. The divisor D is 2, 8, 32, 64 or 128 for clock select 000, 001, 010, 101 or 110.
- R4: While clock select is 100 or 111, the counter does not move.
- R5: Clock select 011 steps the counter once per rising edge of the event input. The edge takes effect after two synchroniser stages, and a level held high counts only once.
- R6: In one-shot mode the pin is active from the trigger until the underflow. It then returns to inactive, and the counter stays at 0 with no further steps.
- R7: The timer stops when the enable is 0. Setting the enable again without a trigger does not resume counting. A trigger while the enable is 0 is ignored.
- R8: A control write that sets the enable takes effect in the same cycle as a trigger that arrives with it, so the timer starts.
- R9: The timer pin equals the internal level XOR the invert bit. After reset the internal level is inactive (0). In reload mode the level starts at 0 on a trigger, and in one-shot mode it starts at 1.
- R10: Each underflow sets the sticky flag. A control write with bit 4 at 0 clears the flag, and a write with bit 4 at 1 leaves it unchanged. The interrupt output is the flag ANDed with the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 reload, 2 counter) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational read data for reg_addr |
| trig | input | 1 | Software trigger strobe |
| ext_evt | input | 1 | External event input (asynchronous) |
| tmr_out | output | 1 | Timer output pin |
| irq | output | 1 | Underflow interrupt |

## Verification
The bound checker watches these rules on every cycle:
- a refill from the reload register after each reload-mode underflow;
- a stop and an inactive level after each one-shot underflow;
- a halt whenever the enable is off;
- a frozen counter under the disabled clock codes, and between event edges;
- the flag and interrupt rising after an underflow.

The exact spacing between underflows for each divisor can only be shown by the directed scenarios, because it spans many prescaler periods. The same holds for the one-shot pulse width window, the event counting after synchronisation, the polarity inversion and the software flag clearing.

// File: rtl/intv_timer_pkg.sv
package intv_timer_pkg;
  localparam int PRE_W = 7;

  typedef enum logic [2:0] {
    SEL_D2    = 3'b000,
    SEL_D8    = 3'b001,
    SEL_D32   = 3'b010,
    SEL_EXT   = 3'b011,
    SEL_OFF_A = 3'b100,
    SEL_D64   = 3'b101,
    SEL_D128  = 3'b110,
    SEL_OFF_B = 3'b111
  } clk_sel_e;

  typedef struct packed {
    clk_sel_e sel;
    logic     flag;
    logic     irq_en;
    logic     invert;
    logic     reload_mode;
    logic     run_en;
  } ctrl_t;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_RELOAD = 2'd1;
  localparam logic [1:0] ADDR_COUNT  = 2'd2;

  // mask of prescaler bits that must all be set for a tick; 0 = no prescaled tick
  function automatic logic [PRE_W-1:0] tick_mask(clk_sel_e s);
    case (s)
      SEL_D2:   return 7'h01;
      SEL_D8:   return 7'h07;
      SEL_D32:  return 7'h1F;
      SEL_D64:  return 7'h3F;
      SEL_D128: return 7'h7F;
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/intv_prescale.sv
module intv_prescale
  import intv_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  clk_sel_e sel,
  input  logic     ext_evt,
  output logic     tick,
  output logic     evt_rise
);
  logic [PRE_W-1:0]     pre_q;
  logic [SYNC_STAGES:0] evt_sh;
  logic [PRE_W-1:0]     mask;
  logic                 pre_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      evt_sh <= '0;
    end else begin
      pre_q  <= pre_q + 1'b1;
      evt_sh <= {evt_sh[SYNC_STAGES-1:0], ext_evt};
    end
  end

  assign evt_rise = evt_sh[SYNC_STAGES-1] & ~evt_sh[SYNC_STAGES];
  assign mask     = tick_mask(sel);
  assign pre_tick = (mask != '0) && ((pre_q & mask) == mask);
  assign tick     = (sel == SEL_EXT) ? evt_rise : pre_tick;
endmodule

// File: rtl/intv_regs.sv
module intv_regs
  import intv_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  input  logic             uf,
  output ctrl_t            ctrl_q,
  output logic [CNT_W-1:0] reload_q,
  output logic             ctrl_wr,
  output logic             en_eff,
  output logic             mode_eff
);
  localparam int CTRL_W = $bits(ctrl_t);
  ctrl_t wctrl;

  assign ctrl_wr  = reg_we && (reg_addr == ADDR_CTRL);
  assign wctrl    = ctrl_t'(reg_wdata[CTRL_W-1:0]);
  assign en_eff   = ctrl_wr ? wctrl.run_en      : ctrl_q.run_en;
  assign mode_eff = ctrl_wr ? wctrl.reload_mode : ctrl_q.reload_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.sel         <= wctrl.sel;
        ctrl_q.irq_en      <= wctrl.irq_en;
        ctrl_q.invert      <= wctrl.invert;
        ctrl_q.reload_mode <= wctrl.reload_mode;
        ctrl_q.run_en      <= wctrl.run_en;
      end
      if (uf)
        ctrl_q.flag <= 1'b1;
      else if (ctrl_wr && !wctrl.flag)
        ctrl_q.flag <= 1'b0;
      if (reg_we && reg_addr == ADDR_RELOAD)
        reload_q <= reg_wdata;
    end
  end
endmodule

// File: rtl/intv_core.sv
module intv_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             trig,
  input  logic             en_eff,
  input  logic             mode_eff,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             running_q,
  output logic             lvl_q,
  output logic             load,
  output logic             uf
);
  logic step;

  function automatic logic [CNT_W-1:0] count_down(logic [CNT_W-1:0] v);
    return v - 1'b1;
  endfunction

  assign load = trig & en_eff;
  assign step = running_q & tick;
  assign uf   = step && (cnt_q == '0) && !load && en_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      running_q <= 1'b0;
      lvl_q     <= 1'b0;
    end else if (load) begin
      cnt_q     <= reload;
      running_q <= 1'b1;
      lvl_q     <= !mode_eff;
    end else if (!en_eff) begin
      running_q <= 1'b0;
    end else if (step) begin
      if (cnt_q == '0) begin
        if (mode_eff) begin
          cnt_q <= reload;
          lvl_q <= ~lvl_q;
        end else begin
          running_q <= 1'b0;
          lvl_q     <= 1'b0;
        end
      end else begin
        cnt_q <= count_down(cnt_q);
      end
    end
  end
endmodule

// File: rtl/intv_timer.sv
module intv_timer
  import intv_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             trig,
  input  logic             ext_evt,
  output logic             tmr_out,
  output logic             irq
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ctrl_wr, en_eff, mode_eff;
  logic             tick, evt_rise, load, uf, running_q, lvl_q;
  logic [2:0]       cur_sel;

  assign cur_sel = ctrl_q.sel;

  intv_prescale #(.SYNC_STAGES(SYNC_STAGES)) u_pre (
    .clk(clk), .rst_n(rst_n), .sel(ctrl_q.sel), .ext_evt(ext_evt),
    .tick(tick), .evt_rise(evt_rise)
  );

  intv_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .uf(uf), .ctrl_q(ctrl_q), .reload_q(reload_q),
    .ctrl_wr(ctrl_wr), .en_eff(en_eff), .mode_eff(mode_eff)
  );

  intv_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .trig(trig), .en_eff(en_eff),
    .mode_eff(mode_eff), .reload(reload_q), .cnt_q(cnt_q),
    .running_q(running_q), .lvl_q(lvl_q), .load(load), .uf(uf)
  );

  always_comb begin
    case (reg_addr)
      ADDR_CTRL:   reg_rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
      ADDR_RELOAD: reg_rdata = reload_q;
      ADDR_COUNT:  reg_rdata = cnt_q;
      default:     reg_rdata = '0;
    endcase
  end

  assign tmr_out = lvl_q ^ ctrl_q.invert;
  assign irq     = ctrl_q.flag & ctrl_q.irq_en;
endmodule

// File: rtl/intv_timer_chk.sv
module intv_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       sel,
  input logic             evt_rise,
  input logic             load,
  input logic             uf,
  input logic             en_eff,
  input logic             mode_eff,
  input logic             running_q,
  input logic             lvl_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] reload_q,
  input logic             flag,
  input logic             irq_en,
  input logic             irq
);
  // R3
  reload_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf && mode_eff |=> (cnt_q == $past(reload_q)) && running_q);

  // R6
  oneshot_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf && !mode_eff |=> !running_q && !lvl_q);

  // R7
  disabled_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_eff |=> !running_q);

  // R4
  off_code_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'b100 || sel == 3'b111) && !load |=> $stable(cnt_q));

  // R5
  event_gap_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'b011) && !evt_rise && !load |=> $stable(cnt_q));

  // R10
  flag_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> flag);

  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf && irq_en |=> irq);
endmodule

bind intv_timer intv_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(cur_sel), .evt_rise(evt_rise), .load(load),
  .uf(uf), .en_eff(en_eff), .mode_eff(mode_eff), .running_q(running_q),
  .lvl_q(lvl_q), .cnt_q(cnt_q), .reload_q(reload_q), .flag(ctrl_q.flag),
  .irq_en(ctrl_q.irq_en), .irq(irq)
);

// File: tb/sim_intv_timer.sv
`timescale 1ns/1ps
module sim_intv_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        trig = 1'b0;
  logic        ext_evt = 1'b0;
  logic        tmr_out;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  intv_timer u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig(trig),
    .ext_evt(ext_evt), .tmr_out(tmr_out), .irq(irq)
  );

  function automatic logic [15:0] ctl(logic en, logic rl, logic inv, logic ie,
                                      logic fl, logic [2:0] sel);
    return {8'd0, sel, fl, ie, inv, rl, en};
  endfunction

  function automatic int divisor(logic [2:0] sel);
    case (sel)
      3'b000: return 2;
      3'b001: return 8;
      3'b010: return 32;
      3'b101: return 64;
      3'b110: return 128;
      default: return 0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic pulse_trig();
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic gap_between_toggles(output int gap);
    logic prev;
    int n;
    prev = tmr_out; n = 0;
    while (tmr_out == prev && n < 3000) begin @(negedge clk); n++; end
    prev = tmr_out; n = 0;
    while (1) begin
      @(negedge clk); n++;
      if (tmr_out != prev || n > 3000) break;
    end
    gap = n;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 pin", tmr_out, 0);
    check("R1 irq", irq, 0);
    rd(2'd0, d); check("R1 ctrl", d, 0);
    rd(2'd1, d); check("R1 reload", d, 0);
    rd(2'd2, d); check("R1 count", d, 0);
  endtask

  task automatic t_trig_disabled();
    logic [15:0] d;
    wr(2'd1, 16'd5);
    pulse_trig();
    rd(2'd2, d); check("R7 trigger ignored when disabled", d, 0);
    check("R7 pin unchanged", tmr_out, 0);
  endtask

  task automatic t_range_and_off();
    logic [15:0] d;
    wr(2'd1, 16'hFFFF);
    rd(2'd1, d); check("R2 reload readback max", d, 16'hFFFF);
    wr(2'd0, ctl(1, 1, 0, 0, 0, 3'b100));
    pulse_trig();
    rd(2'd2, d); check("R2 trigger loads counter", d, 16'hFFFF);
    idle(40);
    rd(2'd2, d); check("R4 code 100 frozen", d, 16'hFFFF);
    wr(2'd0, ctl(1, 1, 0, 0, 0, 3'b111));
    idle(40);
    rd(2'd2, d); check("R4 code 111 frozen", d, 16'hFFFF);
    wr(2'd0, ctl(1, 1, 0, 0, 0, 3'b000));
    idle(10);
    rd(2'd2, d); check("R4 counting resumes on valid code", d != 16'hFFFF, 1);
  endtask

  task automatic one_interval(logic [2:0] sel, logic [15:0] rl, int reps);
    int gap;
    wr(2'd0, 16'd0);
    wr(2'd1, rl);
    wr(2'd0, ctl(1, 1, 0, 0, 0, sel));
    pulse_trig();
    for (int r = 0; r < reps; r++) begin
      gap_between_toggles(gap);
      check($sformatf("R3 interval sel=%b reload=%0d", sel, rl), gap,
            (int'(rl) + 1) * divisor(sel));
    end
  endtask

  task automatic t_intervals();
    one_interval(3'b000, 16'd0, 2);
    one_interval(3'b000, 16'd5, 1);
    one_interval(3'b001, 16'd2, 1);
    one_interval(3'b010, 16'd1, 1);
    one_interval(3'b101, 16'd1, 1);
    one_interval(3'b110, 16'd0, 2);
  endtask

  task automatic ev_pulse();
    ext_evt = 1'b1; idle(2);
    ext_evt = 1'b0; idle(2);
  endtask

  task automatic t_ext();
    logic [15:0] d;
    wr(2'd0, 16'd0);
    wr(2'd1, 16'd4);
    wr(2'd0, ctl(1, 1, 0, 0, 0, 3'b011));
    pulse_trig();
    rd(2'd2, d); check("R5 loaded", d, 4);
    ev_pulse(); ev_pulse(); idle(4);
    rd(2'd2, d); check("R5 two edges counted", d, 2);
    ext_evt = 1'b1; idle(20); ext_evt = 1'b0; idle(4);
    rd(2'd2, d); check("R5 held level counts once", d, 1);
    ev_pulse(); ev_pulse(); idle(4);
    rd(2'd2, d); check("R5 underflow refills", d, 4);
    check("R5 pin toggled", tmr_out, 1);
    rd(2'd0, d); check("R10 flag after event underflow", d[4], 1);
  endtask

  task automatic t_stop();
    logic [15:0] c1, d;
    wr(2'd0, 16'd0);
    wr(2'd1, 16'd1000);
    wr(2'd0, ctl(1, 1, 0, 0, 0, 3'b000));
    pulse_trig();
    idle(20);
    wr(2'd0, ctl(0, 1, 0, 0, 0, 3'b000));
    rd(2'd2, c1);
    idle(20);
    rd(2'd2, d); check("R7 stopped when disabled", d, c1);
    wr(2'd0, ctl(1, 1, 0, 0, 0, 3'b000));
    idle(20);
    rd(2'd2, d); check("R7 no resume without trigger", d, c1);
    pulse_trig();
    rd(2'd2, d); check("R7 trigger restarts", d, 1000);
  endtask

  task automatic t_oneshot();
    logic [15:0] d;
    int n;
    wr(2'd0, 16'd0);
    wr(2'd1, 16'd3);
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = ctl(1, 0, 0, 0, 0, 3'b001);
    trig = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; trig = 1'b0;
    rd(2'd2, d); check("R8 same-cycle enable and trigger loads", d, 3);
    check("R8 pin active after start", tmr_out, 1);
    n = 0;
    while (tmr_out == 1'b1 && n < 200) begin @(negedge clk); n++; end
    check("R6 pulse width in [25,32]", (n >= 25 && n <= 32), 1);
    rd(2'd2, d); check("R6 counter at 0", d, 0);
    idle(50);
    rd(2'd2, d); check("R6 counter stays 0", d, 0);
    check("R6 pin stays inactive", tmr_out, 0);
    rd(2'd0, d); check("R10 flag set", d[4], 1);
    check("R10 irq masked", irq, 0);
    wr(2'd0, ctl(1, 0, 0, 1, 1, 3'b001));
    check("R10 irq with enable, write 1 keeps flag", irq, 1);
    wr(2'd0, ctl(1, 0, 0, 1, 0, 3'b001));
    check("R10 irq cleared", irq, 0);
    rd(2'd0, d); check("R10 flag cleared", d[4], 0);
  endtask

  task automatic t_invert();
    wr(2'd0, ctl(1, 0, 1, 0, 0, 3'b001));
    check("R9 inverted idle pin", tmr_out, 1);
    pulse_trig();
    check("R9 inverted active pin", tmr_out, 0);
    idle(40);
    check("R9 inverted after one-shot", tmr_out, 1);
    wr(2'd0, ctl(1, 0, 0, 0, 0, 3'b001));
    check("R9 normal polarity restored", tmr_out, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_trig_disabled();
    t_range_and_off();
    t_intervals();
    t_ext();
    t_stop();
    t_oneshot();
    t_invert();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule